// File: doc/BRIEF.md
# Edge-Timestamping Capture Unit

This block timestamps transitions on up to four external inputs. A shared free-running counter, slowed by a programmable divider, supplies the time base. Each channel re-times its input into the local clock, watches for the transition kind that software picked for it, and on a match copies the counter into its own capture register and raises a pending flag. Pending flags are gated by per-channel enables and merged into a single interrupt line.

Software programs the block through a small word-addressed register port with a single-cycle write strobe and a combinational read path. A typical use is measuring a pulse: arm a channel for rising edges, read the first stamp, acknowledge, switch to falling edges, then subtract stamps to get the high time in divided clock ticks.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset every readable register (control 0x50, enable 0x54, pending 0x58, stamps, selectors) reads 0 and `irq` is 0.
- R2: Each channel's 2-bit selector chooses the trigger: 1 captures on a low-to-high input change only, 2 on high-to-low only, 3 on either change.
- R3: A channel whose selector is 0 never updates its stamp and never sets its pending flag.
- R4: While control bit 10 (capture run) is 0 the counter holds and no channel captures or flags.
- R5: While running, the counter advances by one every (P+1) clock cycles, where P is control bits 8:4; control reads back the run bit at 10 and P at 8:4.
- R6: On a matching transition the channel stores the counter value in its stamp register and sets its pending flag at bit (channel+1) of register 0x58; the difference of two stamps equals the cycles between the two transitions divided by (P+1).
- R7: `irq` is high exactly when some channel has both its pending flag and its enable bit (bit channel+1 of 0x54) set.
- R8: A write to 0x5C clears each pending flag whose matching bit (channel+1) in the written data is 1 and leaves the others; writing 0x1FF clears all.
- R9: Channel x's stamp reads at byte address 0x10+4x and its selector reads and writes at 0x30+4x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | NCH | Asynchronous capture inputs, one per channel |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Merged interrupt request |

## Verification
Each trigger kind is tried with a pulse whose wrong-direction transition must leave the pending flags untouched, so rising, falling and either-edge modes are told apart, and a zero-selector channel follows the same waveform to show it stays silent. Stamp differences are taken once with an undivided time base and once with a divider of four, which separates a correct divider from an off-by-one one. Two channels pending at once, with a partial acknowledge and changing enables, separate per-bit clearing from a global clear and show the interrupt follows enable gating; a final capture attempt with the run bit cleared shows the block frozen.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
    localparam int unsigned MAX_CH      = 4;
    localparam logic [7:0]  A_CTRL      = 8'h50;
    localparam logic [7:0]  A_IEN       = 8'h54;
    localparam logic [7:0]  A_PEND      = 8'h58;
    localparam logic [7:0]  A_ACK       = 8'h5C;
    localparam logic [3:0]  PAGE_STAMP  = 4'h1;
    localparam logic [3:0]  PAGE_SEL    = 4'h3;
    localparam int unsigned RUN_BIT     = 10;
    localparam int unsigned DIV_LSB     = 4;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_ANY  = 2'd3
    } trig_e;
endpackage

// File: rtl/ecap_timebase.sv
module ecap_timebase #(
    parameter int unsigned CW = 32,
    parameter int unsigned PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] div,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] phase;
        logic [CW-1:0] cnt;
    } tb_t;

    tb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.phase = '0;
        end else if (st_q.phase >= div) begin
            st_d.phase = '0;
            st_d.cnt   = st_q.cnt + CW'(1);
        end else begin
            st_d.phase = st_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/ecap_channel.sv
module ecap_channel
    import ecap_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic [1:0]    sel,
    input  logic          run,
    input  logic [CW-1:0] count,
    input  logic          clr,
    output logic [CW-1:0] stamp,
    output logic          flag
);
    typedef struct packed {
        logic          meta;
        logic          sync;
        logic          prev;
        logic [CW-1:0] stamp;
        logic          flag;
    } ch_t;

    ch_t   ch_d, ch_q;
    logic  rise, fall, hit;
    trig_e mode;

    always_comb begin
        mode = trig_e'(sel);
        rise = ch_q.sync & ~ch_q.prev;
        fall = ~ch_q.sync & ch_q.prev;
        unique case (mode)
            TRIG_RISE: hit = rise;
            TRIG_FALL: hit = fall;
            TRIG_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        hit = hit & run;

        ch_d      = ch_q;
        ch_d.meta = pin;
        ch_d.sync = ch_q.meta;
        ch_d.prev = ch_q.sync;
        if (clr) ch_d.flag = 1'b0;
        if (hit) begin
            ch_d.stamp = count;
            ch_d.flag  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign stamp = ch_q.stamp;
    assign flag  = ch_q.flag;
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecap_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 32,
    parameter int unsigned PW  = 5,
    parameter int unsigned AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cap_pin,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           irq
);
    localparam int unsigned IW = 2;

    typedef struct packed {
        logic                    run;
        logic [PW-1:0]           div;
        logic [NCH-1:0]          ien;
        logic [NCH-1:0][1:0]     sel;
    } cfg_t;

    cfg_t                     cfg_d, cfg_q;
    logic [CW-1:0]            count;
    logic [NCH-1:0][CW-1:0]   stamp;
    logic [NCH-1:0]           flags;
    logic [NCH-1:0]           clr;
    logic [7:0]               addr8;
    logic [IW-1:0]            idx;
    logic                     idx_ok;
    logic                     is_ack;

    always_comb begin
        addr8  = bus_addr[7:0];
        idx    = addr8[3:2];
        idx_ok = (int'(idx) < int'(NCH)) && (addr8[1:0] == 2'b00);
        is_ack = bus_we && (addr8 == A_ACK);
    end

    always_comb begin
        cfg_d = cfg_q;
        if (bus_we) begin
            if (addr8 == A_CTRL) begin
                cfg_d.run = bus_wdata[RUN_BIT];
                cfg_d.div = bus_wdata[DIV_LSB +: PW];
            end else if (addr8 == A_IEN) begin
                cfg_d.ien = bus_wdata[1 +: NCH];
            end else if (addr8[7:4] == PAGE_SEL && idx_ok) begin
                cfg_d.sel[idx] = bus_wdata[1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    ecap_timebase #(.CW(CW), .PW(PW)) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_q.run),
        .div   (cfg_q.div),
        .count (count)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign clr[g] = is_ack && bus_wdata[g+1];
        ecap_channel #(.CW(CW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cap_pin[g]),
            .sel   (cfg_q.sel[g]),
            .run   (cfg_q.run),
            .count (count),
            .clr   (clr[g]),
            .stamp (stamp[g]),
            .flag  (flags[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (addr8 == A_CTRL) begin
            bus_rdata[RUN_BIT]        = cfg_q.run;
            bus_rdata[DIV_LSB +: PW]  = cfg_q.div;
        end else if (addr8 == A_IEN) begin
            bus_rdata[1 +: NCH] = cfg_q.ien;
        end else if (addr8 == A_PEND) begin
            bus_rdata[1 +: NCH] = flags;
        end else if (addr8[7:4] == PAGE_STAMP && idx_ok) begin
            bus_rdata = 32'(stamp[idx]);
        end else if (addr8[7:4] == PAGE_SEL && idx_ok) begin
            bus_rdata[1:0] = cfg_q.sel[idx];
        end
    end

    assign irq = |(flags & cfg_q.ien);

    initial begin
        if (NCH < 1 || NCH > MAX_CH || CW > 32 || AW < 8)
            $error("edge_capture_unit: unsupported parameters");
    end
endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk
    import ecap_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 32,
    parameter int unsigned AW  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [AW-1:0]          bus_addr,
    input logic [31:0]            bus_wdata,
    input logic                   irq,
    input logic                   run,
    input logic [CW-1:0]          count,
    input logic [NCH-1:0][1:0]    sel,
    input logic [NCH-1:0]         flags,
    input logic [NCH-1:0]         ien,
    input logic [NCH-1:0][CW-1:0] stamp
);
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> $stable(count)); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> ((count - $past(count)) <= CW'(1))); // R5

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != '0)); // R7

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_FLAG_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[g]) |-> ($past(sel[g]) != 2'b00 && $past(run))); // R3

        AST_FLAG_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[g]) |-> $past(bus_we && bus_addr[7:0] == A_ACK && bus_wdata[g+1])); // R8

        AST_STAMP_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(stamp[g]) |-> flags[g]); // R6
    end
endmodule

bind edge_capture_unit edge_capture_unit_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run       (cfg_q.run),
    .count     (count),
    .sel       (cfg_q.sel),
    .flags     (flags),
    .ien       (cfg_q.ien),
    .stamp     (stamp)
);

// File: tb/edge_capture_unit_bench.sv
module edge_capture_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] cap_pin = '0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           irq;

    int total = 0;
    int bad = 0;
    int cyc_no = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] val;
    } exp_t;
    exp_t        sb_q[$];
    logic [31:0] got_val;
    event        got_ev;

    edge_capture_unit #(.NCH(NCH)) u_edge_capture_unit (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc_no <= cyc_no + 1;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    // scoreboard: driver pushes, monitor pops and compares
    task automatic expect_item(input string tag, input logic [31:0] v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        sb_q.push_back(e);
    endtask

    task automatic deliver(input logic [31:0] v);
        got_val = v;
        ->got_ev;
        #1;
    endtask

    initial begin : monitor
        forever begin
            @(got_ev);
            if (sb_q.size() == 0) check("scoreboard underrun", got_val, 32'hx);
            else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, got_val, e.val);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic at_cycle(input int t);
        while (cyc_no < t) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic setpin(input int ch, input logic v);
        @(negedge clk);
        cap_pin[ch] = v;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        logic [31:0] v, a, b;
        int t0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(8'h50, v); check("R1 ctrl", v, 0);
        rd(8'h54, v); check("R1 ien", v, 0);
        rd(8'h58, v); check("R1 pend", v, 0);
        rd(8'h10, v); check("R1 stamp0", v, 0);
        rd(8'h3C, v); check("R1 sel3", v, 0);
        check("R1 irq", 32'(irq), 0);

        // R9 selector placement
        wr(8'h30, 1); wr(8'h34, 2); wr(8'h38, 3); wr(8'h3C, 0);
        rd(8'h30, v); check("R9 sel0", v, 1);
        rd(8'h34, v); check("R9 sel1", v, 2);
        rd(8'h38, v); check("R9 sel2", v, 3);

        // R5 control layout
        wr(8'h50, 32'h400);
        rd(8'h50, v); check("R5 ctrl readback", v, 32'h400);

        // ch0 rising, ch3 disabled follows same waveform
        t0 = cyc_no + 2;
        at_cycle(t0); cap_pin[0] = 1'b1; cap_pin[3] = 1'b1;
        cyc(6);
        rd(8'h58, v); check("R6 R3 pend after rise", v, 32'h2);
        rd(8'h10, a);
        wr(8'h5C, 32'h1FF);
        rd(8'h58, v); check("R8 clear all", v, 0);
        @(negedge clk); cap_pin[0] = 1'b0; cap_pin[3] = 1'b0;
        cyc(6);
        rd(8'h58, v); check("R2 rising ignores fall", v, 0);
        at_cycle(t0 + 40); cap_pin[0] = 1'b1; cap_pin[3] = 1'b1;
        cyc(6);
        rd(8'h10, b);
        expect_item("R6 rise-to-rise stamp delta", 40);
        deliver(b - a);
        rd(8'h1C, v); check("R3 disabled stamp", v, 0);
        rd(8'h58, v); check("R3 disabled flag", v, 32'h2);
        wr(8'h5C, 32'h1FF);

        // ch1 falling
        t0 = cyc_no + 2;
        at_cycle(t0); cap_pin[1] = 1'b1;
        cyc(6);
        rd(8'h58, v); check("R2 falling ignores rise", v, 0);
        at_cycle(t0 + 10); cap_pin[1] = 1'b0;
        cyc(6);
        rd(8'h58, v); check("R2 falling captures", v, 32'h4);
        rd(8'h14, a);
        wr(8'h5C, 32'h4);
        at_cycle(t0 + 30); cap_pin[1] = 1'b1;
        at_cycle(t0 + 50); cap_pin[1] = 1'b0;
        cyc(6);
        rd(8'h14, b);
        expect_item("R6 fall-to-fall stamp delta", 40);
        deliver(b - a);
        wr(8'h5C, 32'h1FF);

        // ch2 either edge with divider 4
        wr(8'h50, 32'h430);
        rd(8'h50, v); check("R5 ctrl divider", v, 32'h430);
        t0 = cyc_no + 2;
        at_cycle(t0); cap_pin[2] = 1'b1;
        cyc(6);
        rd(8'h58, v); check("R2 any-edge rise", v, 32'h8);
        rd(8'h18, a);
        wr(8'h5C, 32'h8);
        at_cycle(t0 + 40); cap_pin[2] = 1'b0;
        cyc(6);
        rd(8'h58, v); check("R2 any-edge fall", v, 32'h8);
        rd(8'h18, b);
        expect_item("R5 divided delta", 10);
        deliver(b - a);
        wr(8'h5C, 32'h1FF);

        // R7 / R8 interrupt gating and partial clear
        setpin(0, 1'b0); setpin(0, 1'b1);
        setpin(1, 1'b1); setpin(1, 1'b0);
        cyc(6);
        rd(8'h58, v); check("R6 two pending", v, 32'h6);
        check("R7 irq masked", 32'(irq), 0);
        wr(8'h54, 32'h2);
        cyc(1); check("R7 irq enabled", 32'(irq), 1);
        wr(8'h5C, 32'h2);
        rd(8'h58, v); check("R8 partial clear", v, 32'h4);
        check("R7 irq after clear", 32'(irq), 0);
        wr(8'h54, 32'h4);
        cyc(1); check("R7 irq other enable", 32'(irq), 1);
        wr(8'h5C, 32'h1FF);
        cyc(1); check("R8 irq cleared", 32'(irq), 0);

        // R4 run off
        wr(8'h50, 32'h0);
        rd(8'h10, a);
        setpin(0, 1'b0); setpin(0, 1'b1);
        cyc(6);
        rd(8'h58, v); check("R4 no flag when stopped", v, 0);
        rd(8'h10, v); check("R4 stamp unchanged", v, a);

        cyc(2);
        if (sb_q.size() != 0) check("scoreboard leftover", 32'(sb_q.size()), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule